// File: doc/BRIEF.md
# Symmetric Divide-by-81 Clock Divider

This block takes a source clock and produces a clock at one eighty-first of its frequency with an exact 50% duty cycle, even though the ratio is odd. The ratio is split into identical odd stages wired in a ripple chain, where each stage's output is the clock of the next. A stage reaches its half-period of 1.5 (or 4.5) source periods by using both edges of its own clock. It holds one toggle flop on the rising edge and one on the falling edge, and its output is the XOR of the two. A mod-N counter on the rising edge decides when each toggle fires.

The last stage output is retimed by a double-edge flop pair clocked by the source clock. The edges of the delivered clock therefore sit on source-clock edges, one half source period after the ripple chain settles, and all ripple delay is removed from them. A build-time parameter picks the factoring: either four divide-by-3 stages (the default) or two divide-by-9 stages. The overall ratio is 81 in both cases. Each stage output is brought out on a debug tap. An enable freezes the whole chain, and an active-low asynchronous reset clears it.

Top module: `sym_div_cascade`

## Requirements
- R1: With enable held high, `divOut` has a period of exactly 81 source clock periods.
- R2: In the default factoring, `stageTap[k]` (k = 0..3, tap 0 nearest the source) toggles every 3^(k+1) source half-periods, so stage k divides the source by 3^(k+1) with equal high and low times.
- R3: Every high time and every low time of `divOut` lasts exactly 81 source half-periods (40.5 source periods).
- R4: Every transition of `divOut` occurs exactly one source half-period after the corresponding transition of the last stage tap, on a source clock edge.
- R5: While `rstN` is low, `divOut` and all `stageTap` bits are 0, independent of the clock.
- R6: While `enable` is low, every stage and `divOut` hold their values; the stage taps do not change at all, and `divOut` changes at most once, at the first source edge after the drop, as it finishes retiming.
- R7: Starting from reset with enable low, the first source rising edge sampled with enable high drives every used stage tap to 1, and `divOut` rises at the following source falling edge.
- R8: With `USE_DIV9` = 1, `stageTap[0]` toggles every 9 and `stageTap[1]` every 81 source half-periods, `stageTap[3:2]` stays 0, and `divOut` keeps the ratio and timing of R1, R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Source clock to be divided |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run when high, freeze when low; sampled on both source edges |
| divOut | output | 1 | Divided, 50% duty, source-retimed clock |
| stageTap | output | 4 | Raw output of each stage, bit 0 first; unused bits are 0 |

## Verification
The bench runs the divider in both factorings. It measures the time between successive transitions of every tap and of `divOut` in source half-periods. This shows whether a stage counts to the wrong modulus, which changes that tap's own interval, or fires its falling-edge toggle at the wrong count, which breaks symmetry without changing the period. Random runs broken up by random-length freezes and by asynchronous resets at random points check that a freeze leaves the chain in phase and that the edge after a freeze is not lost. A directed start-up from reset pins the exact edge of the first output rise. A comparison of `divOut` against the last tap separates a retiming fault from a divider fault.

// File: rtl/symdiv_pkg.sv
`timescale 1ns/1ps
package symdiv_pkg;

  // Number of debug taps brought out at the top; the largest stage count
  localparam int MAX_TAPS = 4;

  // Per-edge step strobes handed from control to the datapath
  typedef struct packed {
    logic riseStep;  // advance the rising-edge state of the first stage
    logic fallStep;  // advance the falling-edge state of the first stage
  } stepStrobe_t;

  // Ratio of one stage for the chosen factoring
  function automatic int stageRatioOf(input bit useNine);
    return useNine ? 9 : 3;
  endfunction

  // Number of stages for the chosen factoring
  function automatic int stageCountOf(input bit useNine);
    return useNine ? 2 : 4;
  endfunction

endpackage

// File: rtl/sym_div_ctrl.sv
`timescale 1ns/1ps
module sym_div_ctrl
  import symdiv_pkg::*;
(
  input  logic        enable,
  output stepStrobe_t step
);

  // Enable gates both edge domains of the first stage. The downstream
  // stages then see no clock edges and hold on their own.
  always_comb begin
    step.riseStep = enable;
    step.fallStep = enable;
  end

endmodule

// File: rtl/sym_odd_stage.sv
`timescale 1ns/1ps
module sym_odd_stage
  import symdiv_pkg::*;
#(
  parameter int RATIO = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  stepStrobe_t step,
  output logic        divOut
);

  localparam int CW      = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int LAST    = RATIO - 1;
  localparam int FALL_AT = (RATIO + 1) / 2;

  logic [CW-1:0] cnt;
  logic          riseTog;
  logic          fallTog;

  // Rising-edge domain: mod-RATIO counter and a toggle at count zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      riseTog <= 1'b0;
    end else if (step.riseStep) begin
      if (cnt == '0) riseTog <= ~riseTog;
      cnt <= (cnt == CW'(LAST)) ? '0 : cnt + 1'b1;
    end
  end

  // Falling-edge domain: toggle half a period after the midpoint count
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      fallTog <= 1'b0;
    end else if (step.fallStep && (cnt == CW'(FALL_AT))) begin
      fallTog <= ~fallTog;
    end
  end

  // Only one of the two flops changes at any edge, so the XOR is clean
  assign divOut = riseTog ^ fallTog;

  // R2: the counter never leaves its modulus range
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(LAST));

  // R6: with the rising step withheld, the rising-edge state holds
  a_r6_rise_hold: assert property (@(posedge clk) disable iff (!rstN)
    !step.riseStep |=> ($stable(cnt) && $stable(riseTog)));

  // R6: with the falling step withheld, the falling-edge toggle holds
  a_r6_fall_hold: assert property (@(negedge clk) disable iff (!rstN)
    !step.fallStep |=> $stable(fallTog));

endmodule

// File: rtl/sym_dual_edge_retime.sv
`timescale 1ns/1ps
module sym_dual_edge_retime (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic riseQ;
  logic fallQ;

  // Each flop stores d XORed with the other, so q equals d as seen at
  // whichever clock edge came last, rising or falling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseQ <= 1'b0;
    else       riseQ <= d ^ fallQ;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallQ <= 1'b0;
    else       fallQ <= d ^ riseQ;
  end

  assign q = riseQ ^ fallQ;

endmodule

// File: rtl/sym_div_datapath.sv
`timescale 1ns/1ps
module sym_div_datapath
  import symdiv_pkg::*;
#(
  parameter int STAGE_RATIO = 3,
  parameter int NUM_STAGES  = 4,
  parameter int TAP_W       = 4
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  stepStrobe_t      step,
  output logic             divOut,
  output logic [TAP_W-1:0] stageTap
);

  localparam int DIV_TOTAL = STAGE_RATIO ** NUM_STAGES;
  localparam int PCW       = $clog2(DIV_TOTAL) + 2;
  localparam stepStrobe_t FREE_RUN = '{riseStep: 1'b1, fallStep: 1'b1};

  // chain[0] is the source clock; chain[i+1] is the output of stage i
  logic [NUM_STAGES:0] chain;
  assign chain[0] = clkIn;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    stepStrobe_t stageStep;
    assign stageStep = (i == 0) ? step : FREE_RUN;

    sym_odd_stage #(.RATIO(STAGE_RATIO)) u_stage (
      .clk    (chain[i]),
      .rstN   (rstN),
      .step   (stageStep),
      .divOut (chain[i+1])
    );
  end

  for (genvar t = 0; t < TAP_W; t++) begin : g_tap
    if (t < NUM_STAGES) begin : g_used
      assign stageTap[t] = chain[t+1];
    end else begin : g_idle
      assign stageTap[t] = 1'b0;
    end
  end

  sym_dual_edge_retime u_retime (
    .clk  (clkIn),
    .rstN (rstN),
    .d    (chain[NUM_STAGES]),
    .q    (divOut)
  );

  // Checker: source rising edges between output rises, skipping any
  // interval during which the chain was frozen
  logic [PCW-1:0] perCnt;
  logic           prevOut;
  logic           armed;
  logic           sawOff;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      perCnt  <= '0;
      prevOut <= 1'b0;
      armed   <= 1'b0;
      sawOff  <= 1'b0;
    end else begin
      prevOut <= divOut;
      if (divOut && !prevOut) begin
        if (armed && !sawOff) begin
          // R1: a full output period spans DIV_TOTAL source periods
          a_r1_period: assert (perCnt == PCW'(DIV_TOTAL - 1))
            else $error("output period off: %0d", perCnt);
        end
        perCnt <= '0;
        armed  <= 1'b1;
        sawOff <= !step.riseStep;
      end else begin
        if (perCnt != '1) perCnt <= perCnt + 1'b1;
        if (!step.riseStep) sawOff <= 1'b1;
      end
    end
  end

  // R5: reset holds the output and every tap low
  a_r5_reset_low: assert property (@(posedge clkIn)
    !rstN |-> (!divOut && (stageTap == '0)));

endmodule

// File: rtl/sym_div_cascade.sv
`timescale 1ns/1ps
module sym_div_cascade
  import symdiv_pkg::*;
#(
  parameter bit USE_DIV9 = 1'b0
) (
  input  logic                clkIn,
  input  logic                rstN,
  input  logic                enable,
  output logic                divOut,
  output logic [MAX_TAPS-1:0] stageTap
);

  localparam int STAGE_RATIO = stageRatioOf(USE_DIV9);
  localparam int NUM_STAGES  = stageCountOf(USE_DIV9);

  stepStrobe_t step;

  sym_div_ctrl u_ctrl (
    .enable (enable),
    .step   (step)
  );

  sym_div_datapath #(
    .STAGE_RATIO (STAGE_RATIO),
    .NUM_STAGES  (NUM_STAGES),
    .TAP_W       (MAX_TAPS)
  ) u_dp (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .step     (step),
    .divOut   (divOut),
    .stageTap (stageTap)
  );

endmodule

// File: tb/tb_sym_div_cascade.sv
`timescale 1ns/1ps
module tb_sym_div_cascade;

  localparam int HALF = 4;          // 8 ns period, 125 MHz
  localparam int NSIG = 8;

  logic clkIn  = 1'b0;
  logic rstN   = 1'b0;
  logic enable = 1'b0;
  logic       divOut, divOut9;
  logic [3:0] tap, tap9;

  sym_div_cascade #(.USE_DIV9(1'b0)) dut (
    .clkIn(clkIn), .rstN(rstN), .enable(enable),
    .divOut(divOut), .stageTap(tap)
  );

  sym_div_cascade #(.USE_DIV9(1'b1)) dut9 (
    .clkIn(clkIn), .rstN(rstN), .enable(enable),
    .divOut(divOut9), .stageTap(tap9)
  );

  always #HALF clkIn = ~clkIn;

  int checks = 0;
  int fails  = 0;
  int halfIdx = 0;

  logic sigPrev [NSIG];
  int   lastIdx [NSIG];
  bit   valid   [NSIG];
  bit   dirty   [NSIG];
  int   expIv   [NSIG];
  logic enEdge;

  function automatic int powInt(input int b, input int e);
    int r = 1;
    for (int k = 0; k < e; k++) r = r * b;
    return r;
  endfunction

  // 0: divOut, 1..4: taps (div3), 5: divOut9, 6..7: taps (div9)
  function automatic logic sigVal(input int i);
    case (i)
      0: return divOut;
      1: return tap[0];
      2: return tap[1];
      3: return tap[2];
      4: return tap[3];
      5: return divOut9;
      6: return tap9[0];
      default: return tap9[1];
    endcase
  endfunction

  function automatic string sigReq(input int i);
    if (i == 0) return "R3";
    if (i < 5)  return "R2";
    return "R8";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    expIv[0] = powInt(3, 4);
    for (int k = 1; k <= 4; k++) expIv[k] = powInt(3, k);
    expIv[5] = powInt(9, 2);
    expIv[6] = powInt(9, 1);
    expIv[7] = powInt(9, 2);
    for (int k = 0; k < NSIG; k++) begin
      sigPrev[k] = 1'b0; lastIdx[k] = 0; valid[k] = 1'b0; dirty[k] = 1'b0;
    end
  end

  // Monitor: one sample per source edge, 1 ns after it
  always @(clkIn) begin
    enEdge = enable;
    #1;
    halfIdx++;
    for (int i = 0; i < NSIG; i++) begin
      logic v;
      v = sigVal(i);
      if (!rstN) begin
        valid[i]   = 1'b0;
        sigPrev[i] = v;
      end else begin
        if (!enEdge) dirty[i] = 1'b1;
        if (v !== sigPrev[i]) begin
          if (valid[i] && !dirty[i])
            check((halfIdx - lastIdx[i]) == expIv[i], sigReq(i),
                  $sformatf("interval of signal %0d", i),
                  halfIdx - lastIdx[i], expIv[i]);
          if (i == 0 && valid[4])
            check(halfIdx == lastIdx[4] + 1, "R4", "divOut after last tap",
                  halfIdx - lastIdx[4], 1);
          if (i == 5 && valid[7])
            check(halfIdx == lastIdx[7] + 1, "R8", "divOut9 after last tap",
                  halfIdx - lastIdx[7], 1);
          lastIdx[i] = halfIdx;
          valid[i]   = 1'b1;
          dirty[i]   = 1'b0;
          sigPrev[i] = v;
        end
      end
    end
  end

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(2 * HALF * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  task automatic checkAllLow(input string req);
    check(divOut == 1'b0, req, "divOut low", int'(divOut), 0);
    check(tap == 4'h0, req, "taps low", int'(tap), 0);
    check(divOut9 == 1'b0, req, "divOut9 low", int'(divOut9), 0);
    check(tap9 == 4'h0, req, "taps9 low", int'(tap9), 0);
  endtask

  initial begin
    logic       snapOut, snapOut9;
    logic [3:0] snapTap, snapTap9;
    void'($urandom(32'd4711));

    // R5: reset state
    repeat (5) @(posedge clkIn);
    @(negedge clkIn); #2;
    checkAllLow("R5");

    // R6: released from reset with enable low, nothing moves
    rstN = 1'b1;
    repeat (40) @(posedge clkIn);
    @(negedge clkIn); #2;
    checkAllLow("R6");

    // R7: first enabled rising edge sets every tap, output follows at fall
    enable = 1'b1;
    @(posedge clkIn); #1;
    check(tap == 4'hF, "R7", "taps after first edge", int'(tap), 15);
    check(divOut == 1'b0, "R7", "divOut before fall", int'(divOut), 0);
    check(tap9 == 4'h3, "R8", "taps9 after first edge", int'(tap9), 3);
    @(negedge clkIn); #1;
    check(divOut == 1'b1, "R7", "divOut at first fall", int'(divOut), 1);
    check(divOut9 == 1'b1, "R8", "divOut9 at first fall", int'(divOut9), 1);

    // Random runs with freezes and asynchronous resets
    for (int ep = 0; ep < 14; ep++) begin
      int runCyc;
      int frz;
      runCyc = $urandom_range(300, 1500);
      repeat (runCyc) @(posedge clkIn);
      @(negedge clkIn); #2;
      if (ep % 4 == 3) begin
        rstN = 1'b0;
        #1;
        checkAllLow("R5");
        repeat (3) @(posedge clkIn);
        @(negedge clkIn); #2;
        rstN = 1'b1;
      end else begin
        enable = 1'b0;
        @(posedge clkIn); #1;
        snapOut = divOut; snapOut9 = divOut9; snapTap = tap; snapTap9 = tap9;
        frz = $urandom_range(2, 40);
        repeat (frz) @(posedge clkIn);
        @(negedge clkIn); #2;
        check(divOut == snapOut, "R6", "divOut frozen", int'(divOut), int'(snapOut));
        check(tap == snapTap, "R6", "taps frozen", int'(tap), int'(snapTap));
        check(divOut9 == snapOut9, "R6", "divOut9 frozen", int'(divOut9), int'(snapOut9));
        check(tap9 == snapTap9, "R6", "taps9 frozen", int'(tap9), int'(snapTap9));
        enable = 1'b1;
      end
    end

    repeat (400) @(posedge clkIn);
    @(negedge clkIn); #2;
    check(tap9[3:2] == 2'b00, "R8", "unused taps", int'(tap9[3:2]), 0);
    finish();
  end

endmodule